// File: doc/BRIEF.md
# Software Interrupt Pending Register with Level Masking

This block holds a vector of seventeen software interrupt pending flags and turns them into per-flag interrupt requests for the core. Software can change the vector in three ways. It can overwrite it outright. It can write a set alias, which turns on the flags whose data bits are 1. It can write a clear alias, which turns off the flags whose data bits are 1. A timer can also raise the top flag with a single-cycle hardware strobe.

A 4-bit interrupt level input masks the requests. Flags 1 to 15 are each compared against their own index. The lowest flag and the top flag instead share a fixed threshold of 14.

The request vector is registered. It always reflects the register contents and the interrupt level as they stand after the most recent clock edge. Each request is raised or withdrawn in the same cycle that a write changes the register or the level.

Top module: `soft_irq_reg`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, the register reads 0, the level reads 15 and every request is 0.
- R2: With `wr_en`=1 and `wr_op`=2'b00 (direct), the register takes `wr_data` at the next clock edge.
- R3: With `wr_en`=1 and `wr_op`=2'b01 (set alias), the register becomes its old value ORed with `wr_data`.
- R4: With `wr_en`=1 and `wr_op`=2'b10 (clear alias), every register bit that is 1 in `wr_data` becomes 0, and the other bits keep their values.
- R5: The register keeps its value when `wr_op`=2'b11 or when `wr_en`=0, whatever `wr_data` holds, unless `hw_set` is asserted.
- R6: A `hw_set` pulse sets bit 16. When it coincides with a direct, set or clear write, bit 16 of the result is 1 and the other bits follow the write.
- R7: For each bit k from 1 to 15, `irq_req[k]` is 1 exactly when register bit k is 1 and k is strictly greater than the level.
- R8: `irq_req[0]` and `irq_req[16]` are 1 exactly when the matching register bit is 1 and the level is below 14.
- R9: With `lvl_wr_en`=1, the level takes `lvl_wr_data`, and all requests are re-evaluated against the register in the same update.
- R10: A request drops in the cycle its condition fails, whether a clear removes the bit or a level write raises the mask.
- R11: Both the register readback and the request vector change one clock edge after the write, strobe or level write that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | Write kind: 00 direct, 01 set alias, 10 clear alias, 11 none |
| wr_data | input | 17 | Write data or bit mask |
| hw_set | input | 1 | Timer strobe that sets bit 16 |
| lvl_wr_en | input | 1 | Interrupt level write strobe |
| lvl_wr_data | input | 4 | New interrupt level |
| reg_q | output | 17 | Register readback |
| lvl_q | output | 4 | Current interrupt level |
| irq_req | output | 17 | Per-bit interrupt requests |

## Verification
The bound checker evaluates these properties on every cycle:
- the result of each write kind, including when the timer strobe coincides with a write;
- that the register and the level hold when nothing writes them;
- that each request bit agrees with the register bit and the level under its own threshold;
- that no request is ever raised for a clear register bit.

Some behaviour can only be shown by the bench's scenarios:
- the reset values;
- the threshold boundaries at levels 13, 14 and 0;
- a request being withdrawn when the level is raised;
- a level write and a register write landing together.

// File: rtl/soft_irq_pkg.sv
package soft_irq_pkg;

  typedef enum logic [1:0] {
    WR_DIRECT = 2'b00,
    WR_SET    = 2'b01,
    WR_CLEAR  = 2'b10,
    WR_NONE   = 2'b11
  } wr_op_e;

  localparam int unsigned SIR_VEC_W   = 17;
  localparam int unsigned SIR_LVL_W   = 4;
  localparam int unsigned SIR_FIX_THR = 14;

endpackage

// File: rtl/soft_irq_rst_sync.sv
module soft_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/soft_irq_update.sv
module soft_irq_update
  import soft_irq_pkg::*;
#(
  parameter int unsigned VEC_W     = SIR_VEC_W,
  parameter int unsigned TIMER_BIT = VEC_W - 1
) (
  input  logic [VEC_W-1:0] cur_q,
  input  logic             wr_en,
  input  logic [1:0]       wr_op,
  input  logic [VEC_W-1:0] wr_data,
  input  logic             hw_set,
  output logic [VEC_W-1:0] nxt_d,
  output logic             load_en
);

  localparam logic [VEC_W-1:0] TIMER_MASK = VEC_W'(1) << TIMER_BIT;

  logic [VEC_W-1:0] sw_val;
  logic             sw_load;

  // software part of the update
  always_comb begin
    sw_val  = cur_q;
    sw_load = 1'b0;
    if (wr_en) begin
      case (wr_op)
        WR_DIRECT: begin
          sw_val  = wr_data;
          sw_load = 1'b1;
        end
        WR_SET: begin
          sw_val  = cur_q | wr_data;
          sw_load = 1'b1;
        end
        WR_CLEAR: begin
          sw_val  = cur_q & ~wr_data;
          sw_load = 1'b1;
        end
        default: begin
          sw_val  = cur_q;
          sw_load = 1'b0;
        end
      endcase
    end
  end

  // timer strobe merges on top of any software result
  always_comb begin
    nxt_d   = sw_val | (hw_set ? TIMER_MASK : '0);
    load_en = sw_load | hw_set;
  end

endmodule

// File: rtl/soft_irq_mask.sv
module soft_irq_mask
  import soft_irq_pkg::*;
#(
  parameter int unsigned VEC_W   = SIR_VEC_W,
  parameter int unsigned LVL_W   = SIR_LVL_W,
  parameter int unsigned FIX_THR = SIR_FIX_THR
) (
  input  logic [VEC_W-1:0] pend,
  input  logic [LVL_W-1:0] lvl,
  output logic [VEC_W-1:0] req
);

  localparam int unsigned TOP_BIT = VEC_W - 1;

  logic lvl_below_fix;

  always_comb begin
    lvl_below_fix = (int'(lvl) < int'(FIX_THR));
  end

  for (genvar gi = 0; gi < VEC_W; gi++) begin : g_bit
    if (gi == 0 || gi == TOP_BIT) begin : g_fixed
      always_comb begin
        req[gi] = pend[gi] & lvl_below_fix;
      end
    end else begin : g_indexed
      always_comb begin
        req[gi] = pend[gi] & (int'(lvl) < gi);
      end
    end
  end

endmodule

// File: rtl/soft_irq_reg.sv
module soft_irq_reg
  import soft_irq_pkg::*;
#(
  parameter int unsigned VEC_W   = SIR_VEC_W,
  parameter int unsigned LVL_W   = SIR_LVL_W,
  parameter int unsigned FIX_THR = SIR_FIX_THR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_op,
  input  logic [VEC_W-1:0] wr_data,
  input  logic             hw_set,
  input  logic             lvl_wr_en,
  input  logic [LVL_W-1:0] lvl_wr_data,
  output logic [VEC_W-1:0] reg_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic [VEC_W-1:0] irq_req
);

  localparam logic [LVL_W-1:0] LVL_RST = '1;

  logic             rst_sync_n;
  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] vec_d;
  logic             vec_en;
  logic [LVL_W-1:0] lvl_r;
  logic [LVL_W-1:0] lvl_d;
  logic [VEC_W-1:0] req_q;
  logic [VEC_W-1:0] req_d;
  logic             req_en;

  soft_irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  soft_irq_update #(.VEC_W(VEC_W), .TIMER_BIT(VEC_W - 1)) u_update (
    .cur_q   (vec_q),
    .wr_en   (wr_en),
    .wr_op   (wr_op),
    .wr_data (wr_data),
    .hw_set  (hw_set),
    .nxt_d   (vec_d),
    .load_en (vec_en)
  );

  always_comb begin
    lvl_d  = lvl_wr_en ? lvl_wr_data : lvl_r;
    req_en = vec_en | lvl_wr_en;
  end

  // requests are evaluated on the post-update values
  soft_irq_mask #(.VEC_W(VEC_W), .LVL_W(LVL_W), .FIX_THR(FIX_THR)) u_mask (
    .pend (vec_d),
    .lvl  (lvl_d),
    .req  (req_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q <= '0;
    end else if (vec_en) begin
      vec_q <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lvl_r <= LVL_RST;
    end else if (lvl_wr_en) begin
      lvl_r <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q <= '0;
    end else if (req_en) begin
      req_q <= req_d;
    end
  end

  assign reg_q   = vec_q;
  assign lvl_q   = lvl_r;
  assign irq_req = req_q;

endmodule

// File: rtl/soft_irq_reg_chk.sv
module soft_irq_reg_chk
  import soft_irq_pkg::*;
#(
  parameter int unsigned VEC_W   = SIR_VEC_W,
  parameter int unsigned LVL_W   = SIR_LVL_W,
  parameter int unsigned FIX_THR = SIR_FIX_THR
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_op,
  input logic [VEC_W-1:0] wr_data,
  input logic             hw_set,
  input logic             lvl_wr_en,
  input logic [LVL_W-1:0] lvl_wr_data,
  input logic [VEC_W-1:0] reg_q,
  input logic [LVL_W-1:0] lvl_q,
  input logic [VEC_W-1:0] irq_req
);

  localparam int unsigned     TOP       = VEC_W - 1;
  localparam logic [VEC_W-1:0] TOP_MASK = VEC_W'(1) << TOP;

  // R2
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == WR_DIRECT) |=>
      reg_q == ($past(wr_data) | ($past(hw_set) ? TOP_MASK : '0)));

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == WR_SET) |=>
      reg_q == ($past(reg_q) | $past(wr_data) | ($past(hw_set) ? TOP_MASK : '0)));

  // R4
  clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == WR_CLEAR) |=>
      reg_q == (($past(reg_q) & ~$past(wr_data)) | ($past(hw_set) ? TOP_MASK : '0)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wr_en || wr_op == WR_NONE) && !hw_set) |=> $stable(reg_q));

  // R6
  timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> reg_q[TOP]);

  // R9
  level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr_en |=> lvl_q == $past(lvl_wr_data));

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_wr_en |=> $stable(lvl_q));

  // R10
  req_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~reg_q) == '0);

  // R8
  low_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] == (reg_q[0] && int'(lvl_q) < int'(FIX_THR)));

  // R8
  top_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[TOP] == (reg_q[TOP] && int'(lvl_q) < int'(FIX_THR)));

  for (genvar gk = 1; gk < TOP; gk++) begin : g_idx
    // R7
    indexed_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[gk] == (reg_q[gk] && int'(lvl_q) < gk));
  end

endmodule

bind soft_irq_reg soft_irq_reg_chk #(
  .VEC_W   (VEC_W),
  .LVL_W   (LVL_W),
  .FIX_THR (FIX_THR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_op       (wr_op),
  .wr_data     (wr_data),
  .hw_set      (hw_set),
  .lvl_wr_en   (lvl_wr_en),
  .lvl_wr_data (lvl_wr_data),
  .reg_q       (reg_q),
  .lvl_q       (lvl_q),
  .irq_req     (irq_req)
);

// File: tb/soft_irq_reg_bench.sv
module soft_irq_reg_bench;

  typedef struct {
    logic [16:0] r;
    logic [3:0]  l;
    logic [16:0] q;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_op;
  logic [16:0] wr_data;
  logic        hw_set;
  logic        lvl_wr_en;
  logic [3:0]  lvl_wr_data;
  logic [16:0] reg_q;
  logic [3:0]  lvl_q;
  logic [16:0] irq_req;

  int   n_chk;
  int   n_fail;
  bit   done;
  exp_t sb[$];

  logic [16:0] m_reg;
  logic [3:0]  m_lvl;

  soft_irq_reg u_soft_irq_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_op       (wr_op),
    .wr_data     (wr_data),
    .hw_set      (hw_set),
    .lvl_wr_en   (lvl_wr_en),
    .lvl_wr_data (lvl_wr_data),
    .reg_q       (reg_q),
    .lvl_q       (lvl_q),
    .irq_req     (irq_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected requests: R7 for bits 1..15 (index above level), R8 for bits 0 and 16 (level below 14)
  function automatic logic [16:0] exp_req(input logic [16:0] r, input logic [3:0] l);
    logic [16:0] e;
    for (int i = 0; i < 17; i++) begin
      if (i == 0 || i == 16) e[i] = r[i] && (int'(l) < 14);
      else                   e[i] = r[i] && (i > int'(l));
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [16:0] er, input logic [3:0] el,
                       input logic [16:0] eq);
    n_chk++;
    if (reg_q !== er || lvl_q !== el || irq_req !== eq) begin
      n_fail++;
      $display("FAIL %s: reg=%h lvl=%0d req=%h expected reg=%h lvl=%0d req=%h",
               tag, reg_q, lvl_q, irq_req, er, el, eq);
    end
  endtask

  // Driver: drives one cycle of stimulus and pushes the expected result.
  task automatic drive(input logic en, input logic [1:0] op, input logic [16:0] d,
                       input logic hs, input logic le, input logic [3:0] ld,
                       input string tag);
    logic [16:0] nr;
    exp_t        it;
    @(negedge clk);
    wr_en       = en;
    wr_op       = op;
    wr_data     = d;
    hw_set      = hs;
    lvl_wr_en   = le;
    lvl_wr_data = ld;
    nr = m_reg;
    if (en) begin
      case (op)
        2'b00:   nr = d;
        2'b01:   nr = m_reg | d;
        2'b10:   nr = m_reg & ~d;
        default: nr = m_reg;
      endcase
    end
    if (hs) nr[16] = 1'b1;
    m_reg = nr;
    if (le) m_lvl = ld;
    it.r   = m_reg;
    it.l   = m_lvl;
    it.q   = exp_req(m_reg, m_lvl);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 2'b00, 17'h0, 1'b0, 1'b0, 4'h0, tag);
  endtask

  // Monitor: one edge after each driven cycle, compare against the queue head
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        check(it.tag, it.r, it.l, it.q);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_op = 2'b00; wr_data = '0; hw_set = 1'b0;
    lvl_wr_en = 1'b0; lvl_wr_data = '0;
    m_reg = '0; m_lvl = 4'hF;
    repeat (3) @(negedge clk);
    check("R1 reset values", 17'h0, 4'hF, 17'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 values after reset release", 17'h0, 4'hF, 17'h0);

    drive(1, 2'b00, 17'h1_0001, 0, 0, 4'h0, "R2 R8 direct write, fixed bits masked at level 15");
    drive(0, 2'b00, 17'h0,      0, 1, 4'hD, "R9 R8 level 13 unmasks fixed bits");
    drive(1, 2'b01, 17'h0_C000, 0, 0, 4'h0, "R3 R7 set alias adds bits 14 and 15");
    drive(1, 2'b10, 17'h0_0001, 0, 0, 4'h0, "R4 R10 clear alias drops bit 0");
    drive(0, 2'b00, 17'h0,      0, 1, 4'hE, "R10 R8 R7 level 14 masks bits 16 and 14");
    drive(1, 2'b11, 17'h1_FFFF, 0, 0, 4'h0, "R5 no-op kind leaves register");
    drive(0, 2'b00, 17'h0_0000, 0, 0, 4'h0, "R5 disabled direct write ignored");
    drive(1, 2'b10, 17'h1_0000, 0, 1, 4'h0, "R4 R9 clear with level write together");
    drive(0, 2'b00, 17'h0,      1, 0, 4'h0, "R6 timer strobe sets bit 16");
    drive(1, 2'b00, 17'h0_0002, 1, 0, 4'h0, "R6 strobe merged into direct write");
    drive(1, 2'b10, 17'h1_0002, 1, 0, 4'h0, "R6 strobe wins over clear of bit 16");
    drive(1, 2'b00, 17'h1_FFFF, 0, 0, 4'h0, "R7 R8 all requests at level 0");
    drive(0, 2'b00, 17'h0,      0, 1, 4'h7, "R7 level 7 keeps bits 8 to 15");
    drive(1, 2'b01, 17'h0_0000, 0, 1, 4'hF, "R10 level 15 withdraws all");
    idle("R11 settled");
    drive(1, 2'b00, 17'h0_0100, 0, 1, 4'h3, "R11 request follows on next edge");
    idle("R5 idle after write");
    repeat (3) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R11: scoreboard left %0d items, expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule